// File: doc/BRIEF.md
# Bit-Serial Configuration Loader

This block loads a configuration image into a programmable target device through a bit-serial slave port. A load request starts a fixed sequence. The block first drops the target's program-request line for a set number of clocks. It then waits for the target to release its init-ready line. Next it shifts the image bytes out one bit per configuration clock, most significant bit first. Finally it keeps the configuration clock running until the target raises its done line. Image bytes come from an upstream source through a valid/ready handshake, and the byte count is given with the request. The configuration clock rate is set by a divider parameter.

The image is sometimes stored as little-endian 32-bit words whose bits must still go out most significant first. For that case a reversal mode is selected at start. In this mode the block gathers each group of four bytes and emits them last-first, so byte index i goes out in position i XOR 3. Examples are a raw legacy image of 10,524 words or any other length that is a multiple of four.

When the load ends, exactly one of three flags is set: success, init timeout or done timeout. That flag holds until the next request. A busy flag covers the whole load, and new requests are ignored while it is set.

Top module: `cfg_loader`

## Requirements
- R1: After reset the block is idle: `prog_n_o` is 1, `cclk_o` is 0, `busy_o`, `byte_ready_o` and all three result flags are 0. `cclk_o` stays 0 whenever `busy_o` is 0.
- R2: A start while idle drives `prog_n_o` low for exactly PROG_CLKS clock cycles, then high again.
- R3: No rising edge of `cclk_o` occurs while `init_n_i` is low after the pulse. If `init_n_i` is still low INIT_TMO cycles after `prog_n_o` returns high, the load ends with `err_init_o` = 1, and no byte is taken and no clock edge is sent.
- R4: Each byte produces exactly 8 rising edges of `cclk_o`. `din_o` changes only while `cclk_o` is low. Within a byte, rising edges are 2*CLK_DIV clock cycles apart.
- R5: With `rev_i` = 0, bytes go out in arrival order, bit 7 first.
- R6: With `rev_i` = 1, data position j carries arriving byte j XOR 3 (order 3,2,1,0,7,6,5,4,...). The length must be a multiple of 4.
- R7: After the last data bit, `cclk_o` keeps toggling until `done_i` is seen high. No rising edge follows that, and the load ends with `ok_o` = 1.
- R8: If `done_i` stays low, the post-data stage ends after DONE_TMO half-periods with `err_done_o` = 1 and `ok_o` = 0. It issues DONE_TMO-1 toggles, which is 8 rising edges for DONE_TMO = 16.
- R9: `busy_o` is 1 from the cycle after an accepted start until the cycle the result is set. The result flags are cleared by an accepted start, at most one is 1 at any time, and exactly one is 1 when `busy_o` falls.
- R10: `start_i` while `busy_o` = 1 is ignored: no new program pulse, and the load in progress finishes unchanged.
- R11: A length of 0 skips the data stage and goes straight to the post-data clocking.
- R12: Exactly `len_i` bytes are accepted per load. `byte_ready_o` stays 0 once that many have been taken, even if the source offers more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Load request, one-cycle pulse |
| len_i | input | LEN_W | Number of image bytes, sampled at start |
| rev_i | input | 1 | 1 = reverse byte order within each 4-byte group, sampled at start |
| byte_data_i | input | 8 | Image byte from source |
| byte_valid_i | input | 1 | Source has a byte |
| byte_ready_o | output | 1 | Block takes the byte this cycle |
| prog_n_o | output | 1 | Program request to target, active low |
| cclk_o | output | 1 | Configuration clock to target |
| din_o | output | 1 | Serial configuration data to target |
| init_n_i | input | 1 | Target init-ready, high when ready for data |
| done_i | input | 1 | Target done indicator |
| busy_o | output | 1 | Load in progress |
| ok_o | output | 1 | Last load completed |
| err_init_o | output | 1 | Last load ended by init-ready timeout |
| err_done_o | output | 1 | Last load ended by done timeout |

## Verification
The hardest case to reach from the ports is the data path in reversal mode while the source inserts idle cycles. That combination exercises the four-byte gather-then-reorder buffer under back-pressure, with the length limit cutting off further bytes. The bench models the target: it drops init-ready during the program pulse and raises it after a chosen delay, or never. It captures `din_o` on every rising `cclk_o`, and it raises done after a chosen number of post-data edges, or never. This lets each table entry steer the load into success, either timeout, or a zero-length load. The expected byte stream, including the XOR-3 order, is computed from a source pattern that keeps offering bytes beyond the length.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    typedef enum logic [2:0] {
        LD_IDLE,
        LD_PULSE,
        LD_WAIT_RDY,
        LD_FETCH,
        LD_SHIFT,
        LD_TAIL
    } ld_state_e;

    typedef enum logic [1:0] {
        RES_NONE,
        RES_OK,
        RES_INIT_TMO,
        RES_DONE_TMO
    } ld_result_e;

endpackage

// File: rtl/cfg_clk_div.sv
module cfg_clk_div #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q == LAST);
        if (!run_i || tick_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/cfg_word_buf.sv
module cfg_word_buf #(
    parameter int GROUP = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush_i,
    input  logic       rev_i,
    input  logic       en_i,
    input  logic [7:0] in_data_i,
    input  logic       in_valid_i,
    output logic       in_ready_o,
    output logic       out_valid_o,
    output logic [7:0] out_data_o,
    input  logic       take_i
);
    localparam int IW = (GROUP > 1) ? $clog2(GROUP) : 1;
    localparam int FW = IW + 1;

    typedef struct packed {
        logic [FW-1:0] fill;
        logic          drain;
        logic [IW-1:0] rd;
    } buf_t;

    buf_t b_d, b_q;
    logic [7:0] slot_q [GROUP];
    logic [FW-1:0] grp_len;
    logic          accept;

    always_comb begin
        grp_len    = rev_i ? FW'(GROUP) : FW'(1);
        in_ready_o = en_i && !b_q.drain;
        accept     = in_ready_o && in_valid_i;
        b_d        = b_q;
        if (flush_i) begin
            b_d = '0;
        end else if (accept) begin
            if (b_q.fill + 1'b1 == grp_len) begin
                b_d.fill  = '0;
                b_d.drain = 1'b1;
                b_d.rd    = IW'(grp_len - 1'b1);
            end else begin
                b_d.fill = b_q.fill + 1'b1;
            end
        end else if (take_i && b_q.drain) begin
            if (b_q.rd == '0) begin
                b_d.drain = 1'b0;
            end else begin
                b_d.rd = b_q.rd - 1'b1;
            end
        end
        out_valid_o = b_q.drain;
        out_data_o  = slot_q[b_q.rd];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    for (genvar g = 0; g < GROUP; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (accept && (b_q.fill[IW-1:0] == IW'(g))) begin
                slot_q[g] <= in_data_i;
            end
        end
    end
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader #(
    parameter int LEN_W     = 16,
    parameter int CLK_DIV   = 4,
    parameter int PROG_CLKS = 64,
    parameter int INIT_TMO  = 4096,
    parameter int DONE_TMO  = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             rev_i,
    input  logic [7:0]       byte_data_i,
    input  logic             byte_valid_i,
    output logic             byte_ready_o,
    output logic             prog_n_o,
    output logic             cclk_o,
    output logic             din_o,
    input  logic             init_n_i,
    input  logic             done_i,
    output logic             busy_o,
    output logic             ok_o,
    output logic             err_init_o,
    output logic             err_done_o
);
    import cfg_loader_pkg::*;

    localparam int WORD_BYTES = 4;
    localparam int CMAX_A = (PROG_CLKS > INIT_TMO) ? PROG_CLKS : INIT_TMO;
    localparam int CMAX   = (CMAX_A > DONE_TMO) ? CMAX_A : DONE_TMO;
    localparam int CW     = $clog2(CMAX + 1);
    localparam logic [CW-1:0] PULSE_LAST = CW'(PROG_CLKS - 1);
    localparam logic [CW-1:0] INIT_LAST  = CW'(INIT_TMO - 1);
    localparam logic [CW-1:0] DONE_LAST  = CW'(DONE_TMO - 1);

    typedef struct packed {
        ld_state_e    st;
        logic [CW-1:0] cnt;
        logic [2:0]    bitn;
        logic [7:0]    shreg;
        logic          cclk;
        logic          din;
        logic          prog_n;
        logic [LEN_W-1:0] sent;
        logic [LEN_W-1:0] acc;
        logic [LEN_W-1:0] len;
        logic          rev;
        ld_result_e    res;
    } ctl_t;

    ctl_t c_d, c_q;

    logic       tick;
    logic       div_run;
    logic       buf_flush;
    logic       buf_en;
    logic       buf_ready;
    logic       buf_out_valid;
    logic [7:0] buf_out_data;
    logic       buf_take;

    cfg_clk_div #(.DIV(CLK_DIV)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (div_run),
        .tick_o (tick)
    );

    cfg_word_buf #(.GROUP(WORD_BYTES)) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (buf_flush),
        .rev_i       (c_q.rev),
        .en_i        (buf_en),
        .in_data_i   (byte_data_i),
        .in_valid_i  (byte_valid_i),
        .in_ready_o  (buf_ready),
        .out_valid_o (buf_out_valid),
        .out_data_o  (buf_out_data),
        .take_i      (buf_take)
    );

    always_comb begin
        c_d       = c_q;
        buf_flush = 1'b0;
        buf_take  = 1'b0;
        div_run   = (c_q.st == LD_SHIFT) || (c_q.st == LD_TAIL);
        buf_en    = ((c_q.st == LD_FETCH) || (c_q.st == LD_SHIFT))
                    && (c_q.acc < c_q.len);

        if (buf_ready && byte_valid_i) begin
            c_d.acc = c_q.acc + 1'b1;
        end

        unique case (c_q.st)
            LD_IDLE: begin
                c_d.prog_n = 1'b1;
                c_d.cclk   = 1'b0;
                if (start_i) begin
                    buf_flush  = 1'b1;
                    c_d.st     = LD_PULSE;
                    c_d.prog_n = 1'b0;
                    c_d.cnt    = '0;
                    c_d.len    = len_i;
                    c_d.rev    = rev_i;
                    c_d.sent   = '0;
                    c_d.acc    = '0;
                    c_d.res    = RES_NONE;
                end
            end
            LD_PULSE: begin
                if (c_q.cnt == PULSE_LAST) begin
                    c_d.prog_n = 1'b1;
                    c_d.cnt    = '0;
                    c_d.st     = LD_WAIT_RDY;
                end else begin
                    c_d.cnt = c_q.cnt + 1'b1;
                end
            end
            LD_WAIT_RDY: begin
                if (init_n_i) begin
                    c_d.cnt = '0;
                    c_d.st  = (c_q.len == '0) ? LD_TAIL : LD_FETCH;
                end else if (c_q.cnt == INIT_LAST) begin
                    c_d.st  = LD_IDLE;
                    c_d.res = RES_INIT_TMO;
                end else begin
                    c_d.cnt = c_q.cnt + 1'b1;
                end
            end
            LD_FETCH: begin
                if (buf_out_valid) begin
                    buf_take   = 1'b1;
                    c_d.shreg  = buf_out_data;
                    c_d.din    = buf_out_data[7];
                    c_d.bitn   = '0;
                    c_d.cclk   = 1'b0;
                    c_d.sent   = c_q.sent + 1'b1;
                    c_d.st     = LD_SHIFT;
                end
            end
            LD_SHIFT: begin
                if (tick) begin
                    if (!c_q.cclk) begin
                        c_d.cclk = 1'b1;
                    end else begin
                        c_d.cclk = 1'b0;
                        if (c_q.bitn == 3'd7) begin
                            c_d.cnt = '0;
                            c_d.st  = (c_q.sent == c_q.len) ? LD_TAIL : LD_FETCH;
                        end else begin
                            c_d.bitn  = c_q.bitn + 1'b1;
                            c_d.shreg = {c_q.shreg[6:0], 1'b0};
                            c_d.din   = c_q.shreg[6];
                        end
                    end
                end
            end
            LD_TAIL: begin
                if (done_i) begin
                    c_d.cclk = 1'b0;
                    c_d.st   = LD_IDLE;
                    c_d.res  = RES_OK;
                end else if (tick) begin
                    if (c_q.cnt == DONE_LAST) begin
                        c_d.cclk = 1'b0;
                        c_d.st   = LD_IDLE;
                        c_d.res  = RES_DONE_TMO;
                    end else begin
                        c_d.cclk = ~c_q.cclk;
                        c_d.cnt  = c_q.cnt + 1'b1;
                    end
                end
            end
            default: c_d.st = LD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q        <= '0;
            c_q.st     <= LD_IDLE;
            c_q.prog_n <= 1'b1;
            c_q.res    <= RES_NONE;
        end else begin
            c_q <= c_d;
        end
    end

    assign byte_ready_o = buf_ready;
    assign prog_n_o     = c_q.prog_n;
    assign cclk_o       = c_q.cclk;
    assign din_o        = c_q.din;
    assign busy_o       = (c_q.st != LD_IDLE);
    assign ok_o         = (c_q.res == RES_OK);
    assign err_init_o   = (c_q.res == RES_INIT_TMO);
    assign err_done_o   = (c_q.res == RES_DONE_TMO);
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic byte_ready_o,
    input logic prog_n_o,
    input logic cclk_o,
    input logic din_o,
    input logic busy_o,
    input logic ok_o,
    input logic err_init_o,
    input logic err_done_o
);
    assert_cclk_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !cclk_o);

    assert_pulse_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n_o |-> busy_o);

    assert_no_clk_in_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n_o |-> !cclk_o);

    assert_din_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cclk_o && $past(cclk_o)) |-> $stable(din_o));

    assert_din_at_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cclk_o) |-> $stable(din_o));

    assert_flags_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ok_o, err_init_o, err_done_o}));

    assert_end_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> ($countones({ok_o, err_init_o, err_done_o}) == 1));

    assert_pulse_from_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prog_n_o) |-> !$past(busy_o));

    assert_ready_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready_o |-> busy_o);
endmodule

bind cfg_loader cfg_loader_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .byte_ready_o (byte_ready_o),
    .prog_n_o     (prog_n_o),
    .cclk_o       (cclk_o),
    .din_o        (din_o),
    .busy_o       (busy_o),
    .ok_o         (ok_o),
    .err_init_o   (err_init_o),
    .err_done_o   (err_done_o)
);

// File: tb/sim_cfg_loader.sv
module sim_cfg_loader;
    localparam int LEN_W = 16;
    localparam int DIV   = 2;
    localparam int PULSE = 3;
    localparam int ITMO  = 20;
    localparam int DTMO  = 16;
    localparam int NEVER = 255;
    localparam int NVEC  = 7;

    typedef struct packed {
        logic [7:0] len;
        logic       rev;
        logic       gaps;
        logic [7:0] idly;
        logic [7:0] dafter;
        logic [1:0] expct;   // 0 ok, 1 init timeout, 2 done timeout
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{8'd4,  1'b0, 1'b0, 8'd4,   8'd3,   2'd0},
        '{8'd8,  1'b1, 1'b0, 8'd2,   8'd0,   2'd0},
        '{8'd5,  1'b0, 1'b1, 8'd6,   8'd5,   2'd0},
        '{8'd12, 1'b1, 1'b1, 8'd1,   8'd1,   2'd0},
        '{8'd2,  1'b0, 1'b0, 8'd255, 8'd2,   2'd1},
        '{8'd4,  1'b1, 1'b0, 8'd3,   8'd255, 2'd2},
        '{8'd0,  1'b0, 1'b0, 8'd2,   8'd2,   2'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic             start = 1'b0;
    logic [LEN_W-1:0] len = '0;
    logic             rev = 1'b0;
    logic [7:0]       bdata;
    logic             bvalid;
    logic             bready;
    logic             prog_n, cclk, din;
    logic             init_n, done;
    logic             busy, ok, ei, ed;

    int checks = 0;
    int fails  = 0;

    logic src_en = 1'b0;
    logic gaps = 1'b0;
    logic mdl_clr = 1'b1;
    int   idly = 0;
    int   dafter = 0;
    int   src_k, cyc, icnt, rises, bad, pulses, prog_low, last_rise, min_gap;
    logic cclk_prev, prog_prev;
    logic [7:0] cap [16];

    function automatic logic [7:0] gen(int k);
        return 8'((k * 53 + 17) % 256) ^ 8'hC3;
    endfunction

    assign bdata  = gen(src_k);
    assign bvalid = src_en && (src_k < int'(len) + 2) && !(gaps && cyc[1]);

    cfg_loader #(
        .LEN_W(LEN_W), .CLK_DIV(DIV), .PROG_CLKS(PULSE),
        .INIT_TMO(ITMO), .DONE_TMO(DTMO)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .len_i(len), .rev_i(rev),
        .byte_data_i(bdata), .byte_valid_i(bvalid), .byte_ready_o(bready),
        .prog_n_o(prog_n), .cclk_o(cclk), .din_o(din),
        .init_n_i(init_n), .done_i(done),
        .busy_o(busy), .ok_o(ok), .err_init_o(ei), .err_done_o(ed)
    );

    // source handshake and target model
    initial begin
        cyc = 0; src_k = 0; icnt = 0; rises = 0; bad = 0; pulses = 0;
        prog_low = 0; last_rise = 0; min_gap = 1000;
        cclk_prev = 1'b0; prog_prev = 1'b1; init_n = 1'b0; done = 1'b0;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mdl_clr) begin
            src_k <= 0; icnt <= 0; rises <= 0; bad <= 0; pulses <= 0;
            prog_low <= 0; last_rise <= 0; min_gap <= 1000;
            cclk_prev <= 1'b0; prog_prev <= 1'b1; init_n <= 1'b0; done <= 1'b0;
        end else begin
            if (bvalid && bready) src_k <= src_k + 1;
            prog_prev <= prog_n;
            cclk_prev <= cclk;
            if (prog_prev && !prog_n) pulses <= pulses + 1;
            if (!prog_n) begin
                prog_low <= prog_low + 1;
                init_n   <= 1'b0;
                icnt     <= 0;
                done     <= 1'b0;
            end else if (!init_n && idly != NEVER) begin
                if (icnt >= idly) init_n <= 1'b1;
                else icnt <= icnt + 1;
            end
            if (cclk && !cclk_prev) begin
                if (!init_n) bad <= bad + 1;
                if (rises < int'(len) * 8)
                    cap[rises / 8] <= {cap[rises / 8][6:0], din};
                if (rises > 0 && (cyc - last_rise) < min_gap)
                    min_gap <= cyc - last_rise;
                last_rise <= cyc;
                rises <= rises + 1;
                if (dafter != NEVER && rises + 1 >= int'(len) * 8 + dafter)
                    done <= 1'b1;
            end
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1", "prog_n in reset", int'(prog_n), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "prog_n idle", int'(prog_n), 1);
        chk("R1", "cclk idle", int'(cclk), 0);
        chk("R1", "busy idle", int'(busy), 0);
        chk("R1", "ready idle", int'(bready), 0);
        chk("R1", "flags idle", int'({ok, ei, ed}), 0);

        for (int v = 0; v < NVEC; v++) begin
            int exp_data, exp_post, exp_acc, mism;
            @(negedge clk);
            mdl_clr = 1'b1;
            len    = LEN_W'(VECS[v].len);
            rev    = VECS[v].rev;
            gaps   = VECS[v].gaps;
            idly   = int'(VECS[v].idly);
            dafter = int'(VECS[v].dafter);
            src_en = 1'b1;
            @(negedge clk);
            mdl_clr = 1'b0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk("R9", $sformatf("v%0d busy after start", v), int'(busy), 1);
            chk("R9", $sformatf("v%0d flags cleared", v), int'({ok, ei, ed}), 0);
            repeat (8) @(negedge clk);
            chk("R10", $sformatf("v%0d busy at second start", v), int'(busy), 1);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            for (int t = 0; t < 6000 && busy; t++) @(negedge clk);
            @(negedge clk);

            case (VECS[v].expct)
                2'd0: begin exp_data = int'(VECS[v].len) * 8; exp_post = dafter; exp_acc = int'(VECS[v].len); end
                2'd1: begin exp_data = 0; exp_post = 0; exp_acc = 0; end
                default: begin exp_data = int'(VECS[v].len) * 8; exp_post = (DTMO) / 2; exp_acc = int'(VECS[v].len); end
            endcase

            chk("R9", $sformatf("v%0d busy ends", v), int'(busy), 0);
            chk("R7", $sformatf("v%0d ok flag", v), int'(ok), int'(VECS[v].expct == 2'd0));
            chk("R3", $sformatf("v%0d init timeout flag", v), int'(ei), int'(VECS[v].expct == 2'd1));
            chk("R8", $sformatf("v%0d done timeout flag", v), int'(ed), int'(VECS[v].expct == 2'd2));
            chk("R2", $sformatf("v%0d pulse width", v), prog_low, PULSE);
            chk("R10", $sformatf("v%0d pulse count", v), pulses, 1);
            chk("R3", $sformatf("v%0d edges while not ready", v), bad, 0);
            chk("R12", $sformatf("v%0d bytes accepted", v), src_k, exp_acc);
            chk("R4", $sformatf("v%0d data edges", v), (rises < exp_data) ? rises : exp_data, exp_data);
            if (VECS[v].expct == 2'd0)
                chk("R7", $sformatf("v%0d tail edges", v), rises - exp_data, exp_post);
            else
                chk("R8", $sformatf("v%0d tail edges", v), rises - exp_data, exp_post);
            if (rises >= 2)
                chk("R4", $sformatf("v%0d min edge spacing", v), min_gap, 2 * DIV);
            if (VECS[v].len == 8'd0)
                chk("R11", $sformatf("v%0d zero length tail", v), rises, exp_post);
            mism = 0;
            for (int j = 0; j < exp_data / 8; j++) begin
                int idx;
                idx = VECS[v].rev ? (j ^ 3) : j;
                if (cap[j] !== gen(idx)) mism++;
            end
            if (VECS[v].rev)
                chk("R6", $sformatf("v%0d reversed byte mismatches", v), mism, 0);
            else
                chk("R5", $sformatf("v%0d byte mismatches", v), mism, 0);
            chk("R1", $sformatf("v%0d cclk low after load", v), int'(cclk), 0);
            chk("R1", $sformatf("v%0d prog_n high after load", v), int'(prog_n), 1);
        end

        // directed: results hold while idle and start pulses after reset re-entry
        repeat (5) @(negedge clk);
        chk("R9", "result holds while idle", int'(ok), 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "flags cleared by reset", int'({ok, ei, ed}), 0);
        chk("R1", "busy cleared by reset", int'(busy), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule